// File: doc/BRIEF.md
# Banked Per-Channel FIFO Event Interrupt Controller

This block gathers event pulses from a set of streaming FIFO channels and turns them into one level-sensitive interrupt line. Each channel can report six kinds of event: almost-empty, almost-full and overflow, each for the capture direction and for the playback direction. Every event is held in a sticky raw-status bit. A per-bit enable selects which held events count. A per-channel top-level mask then decides whether that channel may drive the shared interrupt.

The status bits are packed into 32-bit words. Each channel owns one 8-bit lane, and four channels share a word, so ten channels need three banks. Software reaches the state through a plain address/data port. It writes enables and the top mask, clears held events by writing ones, and reads raw status and masked status (raw AND enable). The FIFOs that produce the pulses sit outside this block.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset every enable bit, every raw status bit and the top-level mask are zero, every register address reads zero, and `irq` is low.
- R2: A one-cycle pulse on `evt_pulse[ch*6+t]` sets raw status bit `8*(ch mod 4)+t` of bank `ch/4`, and no other bit. Type codes `t` are: 0 capture almost-empty, 1 capture almost-full, 2 playback almost-empty, 3 playback almost-full, 4 capture overflow, 5 playback overflow.
- R3: A raw status bit latches on its event whether or not that bit is enabled.
- R4: A masked status bit reads as raw AND enable for the same bank and bit.
- R5: Writing a 1 to a bit at a clear address drops that raw bit. Writing 0 leaves it set, and a set raw bit stays set until it is cleared.
- R6: When an event and a clear for the same bit arrive in the same cycle, the bit ends up set.
- R7: `irq` is high exactly when some channel has a masked status bit set in its lane and that channel's top-mask bit (bit number = channel id) is 1.
- R8: Bits 6 and 7 of every lane, and the lanes of channel slots beyond channel 9 (bank 2 bits 16..31), never hold a 1 in enable or raw status. Writing all ones to enable bank 2 reads back 0x00003F3F, and the top mask keeps only bits 9..0.
- R9: Word addresses are: 0..2 enable banks 0..2, 3..5 clear banks 0..2, 6..8 raw banks 0..2, 9..11 masked banks 0..2, 12 top mask. `rdata` is loaded on the clock edge that samples `rd_en` and holds its value while `rd_en` is low.
- R10: Writes to raw or masked status addresses change no state, and clear addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 60 | Event pulses, bit ch*6+type |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
An event pulse or a register write takes effect at the rising edge that samples it. Because `irq` is a pure function of registered state, it is already correct at the falling edge that follows that rising edge. A read delivers `rdata` at that same falling edge, so reading a register back after a change costs two edges in all. The bench drives every input on a falling edge, holds it for exactly one cycle, and samples results only at the next falling edge, which is the first point where each result is due.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    // Register regions selected by the word address.
    typedef enum logic [2:0] {
        RGN_ENABLE,
        RGN_CLEAR,
        RGN_RAW,
        RGN_MASKED,
        RGN_TOP,
        RGN_NONE
    } reg_region_e;

    // Bit position of an event inside its bank word.
    function automatic int unsigned lane_bit(input int unsigned ch,
                                             input int unsigned ev,
                                             input int unsigned ch_per_bank,
                                             input int unsigned lane_w);
        return (ch % ch_per_bank) * lane_w + ev;
    endfunction

endpackage

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
    parameter int NUM_CH  = 10,
    parameter int NUM_EVT = 6,
    parameter int LANE_W  = 8,
    parameter int DATA_W  = 32,
    parameter int BANK    = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH*NUM_EVT-1:0] evt_pulse,
    input  logic                      en_we,
    input  logic                      clr_we,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         en_q,
    output logic [DATA_W-1:0]         raw_q
);
    localparam int CPB = DATA_W / LANE_W;

    logic [DATA_W-1:0] valid_mask;
    logic [DATA_W-1:0] evt_lane;
    logic [DATA_W-1:0] clr_bits;

    // Route each channel's pulses into its lane; spare positions stay zero.
    for (genvar s = 0; s < CPB; s++) begin : g_slot
        localparam int CH = BANK * CPB + s;
        if (CH < NUM_CH) begin : g_used
            for (genvar e = 0; e < LANE_W; e++) begin : g_bit
                if (e < NUM_EVT) begin : g_evt
                    assign evt_lane[s*LANE_W+e]   = evt_pulse[CH*NUM_EVT+e];
                    assign valid_mask[s*LANE_W+e] = 1'b1;
                end else begin : g_pad
                    assign evt_lane[s*LANE_W+e]   = 1'b0;
                    assign valid_mask[s*LANE_W+e] = 1'b0;
                end
            end
        end else begin : g_spare
            assign evt_lane[s*LANE_W +: LANE_W]   = '0;
            assign valid_mask[s*LANE_W +: LANE_W] = '0;
        end
    end

    assign clr_bits = clr_we ? wdata : '0;

    // New events override a clear of the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            raw_q <= '0;
        end else begin
            if (en_we) begin
                en_q <= wdata & valid_mask;
            end
            raw_q <= (raw_q & ~clr_bits) | evt_lane;
        end
    end

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_bank_pkg::*;
#(
    parameter int NUM_CH   = 10,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int NUM_BANK = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic                             rd_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    input  logic [NUM_BANK-1:0][DATA_W-1:0]  en_all,
    input  logic [NUM_BANK-1:0][DATA_W-1:0]  raw_all,
    input  logic [NUM_BANK-1:0][DATA_W-1:0]  masked_all,
    output logic [NUM_BANK-1:0]              en_we,
    output logic [NUM_BANK-1:0]              clr_we,
    output logic [NUM_CH-1:0]                top_mask,
    output logic [DATA_W-1:0]                rdata
);
    localparam int BANK_W = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(NUM_BANK);
    localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(2 * NUM_BANK);
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(3 * NUM_BANK);
    localparam logic [ADDR_W-1:0] A_TOP = ADDR_W'(4 * NUM_BANK);

    reg_region_e       region;
    logic [BANK_W-1:0] bank_idx;
    logic [DATA_W-1:0] rd_word;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:NUM_CH];

    // Address decode into region and bank.
    always_comb begin
        region   = RGN_NONE;
        bank_idx = '0;
        if (addr < A_CLR) begin
            region   = RGN_ENABLE;
            bank_idx = BANK_W'(addr);
        end else if (addr < A_RAW) begin
            region   = RGN_CLEAR;
            bank_idx = BANK_W'(addr - A_CLR);
        end else if (addr < A_MSK) begin
            region   = RGN_RAW;
            bank_idx = BANK_W'(addr - A_RAW);
        end else if (addr < A_TOP) begin
            region   = RGN_MASKED;
            bank_idx = BANK_W'(addr - A_MSK);
        end else if (addr == A_TOP) begin
            region   = RGN_TOP;
        end
    end

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_strobe
        assign en_we[b]  = wr_en && (region == RGN_ENABLE) && (bank_idx == BANK_W'(b));
        assign clr_we[b] = wr_en && (region == RGN_CLEAR)  && (bank_idx == BANK_W'(b));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_mask <= '0;
        end else if (wr_en && region == RGN_TOP) begin
            top_mask <= wdata[NUM_CH-1:0];
        end
    end

    always_comb begin
        unique case (region)
            RGN_ENABLE: rd_word = en_all[bank_idx];
            RGN_RAW:    rd_word = raw_all[bank_idx];
            RGN_MASKED: rd_word = masked_all[bank_idx];
            RGN_TOP:    rd_word = {{(DATA_W-NUM_CH){1'b0}}, top_mask};
            RGN_CLEAR:  rd_word = '0;
            RGN_NONE:   rd_word = '0;
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_word;
        end
    end

endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int NUM_CH   = 10,
    parameter int LANE_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_BANK = 3
) (
    input  logic [NUM_BANK-1:0][DATA_W-1:0] masked_all,
    input  logic [NUM_CH-1:0]               top_mask,
    output logic                            irq
);
    localparam int CPB = DATA_W / LANE_W;

    logic [NUM_CH-1:0] ch_hit;
    logic              unused_lanes;

    assign unused_lanes = ^masked_all;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign ch_hit[ch] = |masked_all[ch/CPB][(ch%CPB)*LANE_W +: LANE_W];
    end

    assign irq = |(ch_hit & top_mask);

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl #(
    parameter int NUM_CH  = 10,
    parameter int NUM_EVT = 6,
    parameter int LANE_W  = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH*NUM_EVT-1:0] evt_pulse,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    output logic                      irq
);
    localparam int CPB      = DATA_W / LANE_W;
    localparam int NUM_BANK = (NUM_CH + CPB - 1) / CPB;

    logic [NUM_BANK-1:0][DATA_W-1:0] en_q;
    logic [NUM_BANK-1:0][DATA_W-1:0] raw_q;
    logic [NUM_BANK-1:0][DATA_W-1:0] masked;
    logic [NUM_BANK-1:0]             en_we;
    logic [NUM_BANK-1:0]             clr_we;
    logic [NUM_CH-1:0]               top_mask;

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        irq_evt_bank #(
            .NUM_CH (NUM_CH),
            .NUM_EVT(NUM_EVT),
            .LANE_W (LANE_W),
            .DATA_W (DATA_W),
            .BANK   (b)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_pulse(evt_pulse),
            .en_we    (en_we[b]),
            .clr_we   (clr_we[b]),
            .wdata    (wdata),
            .en_q     (en_q[b]),
            .raw_q    (raw_q[b])
        );
        assign masked[b] = raw_q[b] & en_q[b];
    end

    irq_reg_port #(
        .NUM_CH  (NUM_CH),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .NUM_BANK(NUM_BANK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .en_all    (en_q),
        .raw_all   (raw_q),
        .masked_all(masked),
        .en_we     (en_we),
        .clr_we    (clr_we),
        .top_mask  (top_mask),
        .rdata     (rdata)
    );

    irq_merge #(
        .NUM_CH  (NUM_CH),
        .LANE_W  (LANE_W),
        .DATA_W  (DATA_W),
        .NUM_BANK(NUM_BANK)
    ) u_merge (
        .masked_all(masked),
        .top_mask  (top_mask),
        .irq       (irq)
    );

endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk #(
    parameter int NUM_CH   = 10,
    parameter int NUM_EVT  = 6,
    parameter int LANE_W   = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int NUM_BANK = 3
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_CH*NUM_EVT-1:0]       evt_pulse,
    input logic                            wr_en,
    input logic [ADDR_W-1:0]               addr,
    input logic [DATA_W-1:0]               wdata,
    input logic [NUM_BANK-1:0][DATA_W-1:0] raw,
    input logic [NUM_BANK-1:0][DATA_W-1:0] en,
    input logic [NUM_CH-1:0]               top_mask,
    input logic                            irq
);
    localparam int CPB = DATA_W / LANE_W;

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq);

    assert_irq_needs_top_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (top_mask == '0) |-> !irq);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        for (genvar ev = 0; ev < NUM_EVT; ev++) begin : g_ev
            localparam int B = ch / CPB;
            localparam int P = (ch % CPB) * LANE_W + ev;
            localparam logic [ADDR_W-1:0] CA = ADDR_W'(NUM_BANK + B);

            assert_event_latches_R3: assert property (@(posedge clk) disable iff (!rst_n)
                evt_pulse[ch*NUM_EVT+ev] |=> raw[B][P]);

            assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && addr == CA && wdata[P] && !evt_pulse[ch*NUM_EVT+ev]) |=> !raw[B][P]);

            assert_raw_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (raw[B][P] && !(wr_en && addr == CA && wdata[P])) |=> raw[B][P]);
        end
    end

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        for (genvar k = 0; k < DATA_W; k++) begin : g_bit
            localparam int SLOT = k / LANE_W;
            localparam int EV   = k % LANE_W;
            localparam int CH   = b * CPB + SLOT;
            if (EV >= NUM_EVT || CH >= NUM_CH) begin : g_spare
                assert_spare_bit_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
                    !raw[b][k] && !en[b][k]);
            end
        end
    end

endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(
    .NUM_CH  (NUM_CH),
    .NUM_EVT (NUM_EVT),
    .LANE_W  (LANE_W),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .NUM_BANK(NUM_BANK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_pulse(evt_pulse),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .raw      (raw_q),
    .en       (en_q),
    .top_mask (top_mask),
    .irq      (irq)
);

// File: tb/tb_irq_bank_ctrl.sv
module tb_irq_bank_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH  = 10;
    localparam int NUM_EVT = 6;

    // Register addresses (R9)
    localparam logic [3:0] A_EN  = 4'd0;
    localparam logic [3:0] A_CLR = 4'd3;
    localparam logic [3:0] A_RAW = 4'd6;
    localparam logic [3:0] A_MSK = 4'd9;
    localparam logic [3:0] A_TOP = 4'd12;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [NUM_CH*NUM_EVT-1:0] evt_pulse = '0;
    logic                      wr_en = 1'b0;
    logic                      rd_en = 1'b0;
    logic [3:0]                addr = '0;
    logic [31:0]               wdata = '0;
    logic [31:0]               rdata;
    logic                      irq;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_bank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [3:0] bank_of(input int ch);
        return 4'(ch / 4);
    endfunction

    function automatic logic [31:0] bit_of(input int ch, input int t);
        return 32'h1 << ((ch % 4) * 8 + t);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input int ch, input int t);
        evt_pulse[ch*NUM_EVT+t] = 1'b1;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        for (int a = 0; a <= 12; a++) begin
            rd(4'(a), d);
            check("R1 register zero after reset", d, 32'h0);
        end
    endtask

    task automatic t_mapping();
        int chs[4] = '{0, 5, 9, 3};
        int ts[4]  = '{0, 3, 5, 4};
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            pulse(chs[i], ts[i]);
            rd(A_RAW + bank_of(chs[i]), d);
            check("R2 event bit position", d, bit_of(chs[i], ts[i]));
            wr(A_CLR + bank_of(chs[i]), bit_of(chs[i], ts[i]));
            rd(A_RAW + bank_of(chs[i]), d);
            check("R5 write-one clear", d, 32'h0);
        end
    endtask

    task automatic t_enable_gate();
        logic [31:0] d;
        pulse(6, 1);
        rd(A_RAW + 4'd1, d);
        check("R3 raw latches while disabled", d, bit_of(6, 1));
        rd(A_MSK + 4'd1, d);
        check("R4 masked zero while disabled", d, 32'h0);
        check("R7 irq low while disabled", {31'b0, irq}, 32'h0);
        wr(A_EN + 4'd1, bit_of(6, 1));
        rd(A_MSK + 4'd1, d);
        check("R4 masked equals raw and enable", d, bit_of(6, 1));
        check("R7 irq low without top mask", {31'b0, irq}, 32'h0);
        wr(A_TOP, 32'h0000_0200);
        check("R7 irq low with other channel unmasked", {31'b0, irq}, 32'h0);
        wr(A_TOP, 32'h0000_0040);
        check("R7 irq high", {31'b0, irq}, 32'h1);
        wr(A_CLR + 4'd1, bit_of(6, 1));
        check("R7 irq drops after clear", {31'b0, irq}, 32'h0);
        wr(A_EN + 4'd1, 32'h0);
        wr(A_TOP, 32'h0);
    endtask

    task automatic t_w1c_zero();
        logic [31:0] d;
        pulse(2, 2);
        wr(A_CLR, 32'h0);
        rd(A_RAW, d);
        check("R5 zero write leaves bit", d, bit_of(2, 2));
        repeat (3) @(negedge clk);
        rd(A_RAW, d);
        check("R5 bit sticky over idle cycles", d, bit_of(2, 2));
        wr(A_CLR, bit_of(2, 2));
    endtask

    task automatic t_collision();
        logic [31:0] d;
        evt_pulse[8*NUM_EVT+4] = 1'b1;
        wr_en = 1'b1; addr = A_CLR + 4'd2; wdata = bit_of(8, 4);
        @(negedge clk);
        evt_pulse = '0; wr_en = 1'b0; wdata = '0;
        rd(A_RAW + 4'd2, d);
        check("R6 event wins over clear", d, bit_of(8, 4));
        wr(A_CLR + 4'd2, bit_of(8, 4));
        rd(A_RAW + 4'd2, d);
        check("R5 clear after collision", d, 32'h0);
    endtask

    task automatic t_spare_bits();
        logic [31:0] d;
        wr(A_EN + 4'd2, 32'hFFFF_FFFF);
        rd(A_EN + 4'd2, d);
        check("R8 bank 2 enable readback", d, 32'h0000_3F3F);
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, d);
        check("R8 bank 0 enable readback", d, 32'h3F3F_3F3F);
        wr(A_TOP, 32'hFFFF_FFFF);
        rd(A_TOP, d);
        check("R8 top mask width", d, 32'h0000_03FF);
        wr(A_RAW, 32'hFFFF_FFFF);
        rd(A_RAW, d);
        check("R10 raw write ignored", d, 32'h0);
        wr(A_MSK + 4'd1, 32'hFFFF_FFFF);
        rd(A_RAW + 4'd1, d);
        check("R10 masked write ignored", d, 32'h0);
        check("R10 irq unaffected", {31'b0, irq}, 32'h0);
        pulse(1, 0);
        rd(A_CLR, d);
        check("R10 clear address reads zero", d, 32'h0);
        check("R7 irq with full enable and mask", {31'b0, irq}, 32'h1);
        wr(A_CLR, bit_of(1, 0));
        wr(A_EN, 32'h0);
        wr(A_EN + 4'd2, 32'h0);
        wr(A_TOP, 32'h0);
    endtask

    task automatic t_read_hold();
        logic [31:0] d;
        wr(A_TOP, 32'h0000_0155);
        rd(A_TOP, d);
        check("R9 one-cycle read", d, 32'h0000_0155);
        addr = A_RAW;
        pulse(0, 5);
        check("R9 rdata holds without rd_en", rdata, 32'h0000_0155);
        wr(A_CLR, bit_of(0, 5));
        wr(A_TOP, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mapping();
        t_enable_gate();
        t_w1c_zero();
        t_collision();
        t_spare_bits();
        t_read_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule